// File: doc/BRIEF.md
# Address Table Violation Capture

This unit sits beside the address table of a switch and records problems that the forwarding datapath reports about it. The datapath raises one or more violation strobes in a cycle, together with the offending MAC address, the source port number and a port vector. The unit keeps the first such event together with its kind flags, and raises a problem interrupt while that event is pending.

Software services the interrupt by issuing a get-and-clear command with database number zero and waiting for busy to drop. When the command completes, the captured kind flags appear in the operation readback, the MAC address appears in the MAC readback, and the data readback carries the source port in its low nibble and the port vector above it. The capture slot is freed at that moment, so the next event can be taken. Events that arrive while the slot is full are dropped, but a sticky overflow flag records that they happened.

Top module: `viol_capture`

## Requirements
- R1: After reset, irq and busy are 0 and rd_flags, rd_ovf, rd_mac and rd_data are all zero.
- R2: When no event is pending, a cycle with any bit of ev_kind set captures the event, and irq is 1 from the next cycle onward.
- R3: ev_kind bit 0 is age-out, bit 1 member, bit 2 miss, bit 3 table-full. When several bits are set in one cycle, all of them are captured together with the single MAC, source port and port vector of that cycle.
- R4: While an event is pending and no command completes, later events are not captured and irq stays 1. A sticky overflow flag is set instead; it appears on rd_ovf after the next get-and-clear completes and is cleared by that completion.
- R5: A get-and-clear command is cmd_go with cmd_code 3'b111 and cmd_db zero while busy is 0. It raises busy for exactly LAT cycles. A pulse with any other code, a nonzero database number, or a pulse while busy is 0 already high, is ignored.
- R6: In the cycle busy falls, rd_flags holds the captured kind flags, rd_mac the captured MAC, rd_data bits 3:0 the source port and bits from 4 upward the port vector.
- R7: irq drops in the cycle busy falls, unless an event arrives in the completion cycle. In that case the event is captured and irq stays 1.
- R8: A get-and-clear with nothing pending returns zero flags, MAC, data and overflow.
- R9: The readback outputs change only in the cycle a get-and-clear completes. Events that arrive between commands do not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_kind | input | KINDS | Violation strobes (bit 0 age-out, 1 member, 2 miss, 3 full) |
| ev_mac | input | MAC_W | Offending MAC address |
| ev_src | input | SRC_W | Source port number |
| ev_pvec | input | NPORT | Port vector of the offending entry |
| cmd_go | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code; 3'b111 is get-and-clear |
| cmd_db | input | DB_W | Database number; must be zero |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Problem interrupt, high while an event is pending |
| rd_flags | output | KINDS | Kind flags returned by the last command |
| rd_ovf | output | 1 | Overflow flag returned by the last command |
| rd_mac | output | MAC_W | MAC address returned by the last command |
| rd_data | output | SRC_W+NPORT | Port vector above source port, returned by the last command |

## Verification
The assertions check the following on every cycle: the interrupt rises after any strobe, the interrupt holds while no command runs, busy starts or stays low according to the command decode, the interrupt's fall or hold at completion follows the completion-cycle event, and the readback stays stable outside completion. The bench scenarios check the values themselves. They cover which event a command returns, merged kind flags, overflow after a lost event and its clearing, the empty-slot result, and an exact busy length of LAT cycles under a repeated strobe.

// File: rtl/viol_pkg.sv
package viol_pkg;
  localparam int KINDS = 4;
  localparam int KIND_AGE    = 0;
  localparam int KIND_MEMBER = 1;
  localparam int KIND_MISS   = 2;
  localparam int KIND_FULL   = 3;
  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] OP_GETCLR = 3'b111;
endpackage

// File: rtl/vc_cmd_seq.sv
module vc_cmd_seq import viol_pkg::*; #(
  parameter int DB_W = 8,
  parameter int LAT  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [OPC_W-1:0] code,
  input  logic [DB_W-1:0]  db,
  output logic             busy,
  output logic             done
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic [CW-1:0] cnt;
  logic          accept;

  assign accept = go && !busy && (code == OP_GETCLR) && (db == '0);
  assign done   = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= CW'(LAT - 1);
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/vc_capture.sv
module vc_capture import viol_pkg::*; #(
  parameter int MAC_W = 48,
  parameter int SRC_W = 4,
  parameter int NPORT = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [KINDS-1:0] ev_kind,
  input  logic [MAC_W-1:0] ev_mac,
  input  logic [SRC_W-1:0] ev_src,
  input  logic [NPORT-1:0] ev_pvec,
  input  logic             release_i,
  output logic             pending,
  output logic [KINDS-1:0] cap_flags,
  output logic [MAC_W-1:0] cap_mac,
  output logic [SRC_W-1:0] cap_src,
  output logic [NPORT-1:0] cap_pvec,
  output logic             cap_ovf
);
  logic ev_any;
  assign ev_any = |ev_kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      cap_flags <= '0;
      cap_mac   <= '0;
      cap_src   <= '0;
      cap_pvec  <= '0;
      cap_ovf   <= 1'b0;
    end else if (release_i) begin
      cap_ovf <= 1'b0;
      pending <= ev_any;
      if (ev_any) begin
        cap_flags <= ev_kind;
        cap_mac   <= ev_mac;
        cap_src   <= ev_src;
        cap_pvec  <= ev_pvec;
      end else begin
        cap_flags <= '0;
        cap_mac   <= '0;
        cap_src   <= '0;
        cap_pvec  <= '0;
      end
    end else if (ev_any) begin
      if (pending) begin
        cap_ovf <= 1'b1;
      end else begin
        pending   <= 1'b1;
        cap_flags <= ev_kind;
        cap_mac   <= ev_mac;
        cap_src   <= ev_src;
        cap_pvec  <= ev_pvec;
      end
    end
  end
endmodule

// File: rtl/vc_readback.sv
module vc_readback import viol_pkg::*; #(
  parameter int MAC_W = 48,
  parameter int SRC_W = 4,
  parameter int NPORT = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [KINDS-1:0]       flags,
  input  logic                   ovf,
  input  logic [MAC_W-1:0]       mac,
  input  logic [SRC_W-1:0]       src,
  input  logic [NPORT-1:0]       pvec,
  output logic [KINDS-1:0]       rd_flags,
  output logic                   rd_ovf,
  output logic [MAC_W-1:0]       rd_mac,
  output logic [SRC_W+NPORT-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_flags <= '0;
      rd_ovf   <= 1'b0;
      rd_mac   <= '0;
      rd_data  <= '0;
    end else if (load) begin
      rd_flags <= flags;
      rd_ovf   <= ovf;
      rd_mac   <= mac;
      rd_data  <= {pvec, src};
    end
  end
endmodule

// File: rtl/viol_capture.sv
module viol_capture import viol_pkg::*; #(
  parameter int MAC_W = 48,
  parameter int SRC_W = 4,
  parameter int NPORT = 11,
  parameter int DB_W  = 8,
  parameter int LAT   = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [KINDS-1:0]       ev_kind,
  input  logic [MAC_W-1:0]       ev_mac,
  input  logic [SRC_W-1:0]       ev_src,
  input  logic [NPORT-1:0]       ev_pvec,
  input  logic                   cmd_go,
  input  logic [OPC_W-1:0]       cmd_code,
  input  logic [DB_W-1:0]        cmd_db,
  output logic                   busy,
  output logic                   irq,
  output logic [KINDS-1:0]       rd_flags,
  output logic                   rd_ovf,
  output logic [MAC_W-1:0]       rd_mac,
  output logic [SRC_W+NPORT-1:0] rd_data
);
  logic             done;
  logic             pending;
  logic [KINDS-1:0] cap_flags;
  logic [MAC_W-1:0] cap_mac;
  logic [SRC_W-1:0] cap_src;
  logic [NPORT-1:0] cap_pvec;
  logic             cap_ovf;

  vc_cmd_seq #(.DB_W(DB_W), .LAT(LAT)) u_seq (
    .clk(clk), .rst(rst), .go(cmd_go), .code(cmd_code), .db(cmd_db),
    .busy(busy), .done(done)
  );

  vc_capture #(.MAC_W(MAC_W), .SRC_W(SRC_W), .NPORT(NPORT)) u_cap (
    .clk(clk), .rst(rst), .ev_kind(ev_kind), .ev_mac(ev_mac),
    .ev_src(ev_src), .ev_pvec(ev_pvec), .release_i(done),
    .pending(pending), .cap_flags(cap_flags), .cap_mac(cap_mac),
    .cap_src(cap_src), .cap_pvec(cap_pvec), .cap_ovf(cap_ovf)
  );

  vc_readback #(.MAC_W(MAC_W), .SRC_W(SRC_W), .NPORT(NPORT)) u_rb (
    .clk(clk), .rst(rst), .load(done), .flags(cap_flags), .ovf(cap_ovf),
    .mac(cap_mac), .src(cap_src), .pvec(cap_pvec),
    .rd_flags(rd_flags), .rd_ovf(rd_ovf), .rd_mac(rd_mac), .rd_data(rd_data)
  );

  assign irq = pending;
endmodule

// File: rtl/vc_checker.sv
module vc_checker import viol_pkg::*; #(
  parameter int MAC_W = 48,
  parameter int SRC_W = 4,
  parameter int NPORT = 11,
  parameter int DB_W  = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [KINDS-1:0]       ev_kind,
  input logic                   cmd_go,
  input logic [OPC_W-1:0]       cmd_code,
  input logic [DB_W-1:0]        cmd_db,
  input logic                   busy,
  input logic                   irq,
  input logic [KINDS-1:0]       rd_flags,
  input logic                   rd_ovf,
  input logic [MAC_W-1:0]       rd_mac,
  input logic [SRC_W+NPORT-1:0] rd_data
);
  logic start_ok;
  assign start_ok = cmd_go && (cmd_code == OP_GETCLR) && (cmd_db == '0);

  // R2
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq && (|ev_kind)) |=> irq);

  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !busy) |=> irq);

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_ok) |=> busy);

  // R5
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_ok) |=> !busy);

  // R7
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(|ev_kind)) |-> !irq);

  // R7
  irq_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(|ev_kind)) |-> irq);

  // R9
  rd_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy) |-> ($stable(rd_flags) && $stable(rd_mac)
                      && $stable(rd_data) && $stable(rd_ovf)));
endmodule

bind viol_capture vc_checker #(
  .MAC_W(MAC_W), .SRC_W(SRC_W), .NPORT(NPORT), .DB_W(DB_W)
) u_chk (
  .clk(clk), .rst(rst), .ev_kind(ev_kind), .cmd_go(cmd_go),
  .cmd_code(cmd_code), .cmd_db(cmd_db), .busy(busy), .irq(irq),
  .rd_flags(rd_flags), .rd_ovf(rd_ovf), .rd_mac(rd_mac), .rd_data(rd_data)
);

// File: tb/viol_capture_test.sv
module viol_capture_test;
  localparam int LAT = 3;

  typedef struct packed {
    logic [3:0]  k;
    logic [47:0] mac;
    logic [3:0]  src;
    logic [10:0] pv;
  } vec_t;

  localparam vec_t TBL [0:4] = '{
    '{4'b0001, 48'h0011_2233_4455, 4'h2, 11'h004},
    '{4'b0010, 48'hA0B1_C2D3_E4F5, 4'h7, 11'h080},
    '{4'b0100, 48'h0200_0000_0001, 4'hA, 11'h400},
    '{4'b1010, 48'hFFFF_FFFF_FFFE, 4'h0, 11'h001},
    '{4'b1111, 48'h5A5A_A5A5_3C3C, 4'hF, 11'h7FF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ev_kind = '0;
  logic [47:0] ev_mac = '0;
  logic [3:0]  ev_src = '0;
  logic [10:0] ev_pvec = '0;
  logic        cmd_go = 1'b0;
  logic [2:0]  cmd_code = '0;
  logic [7:0]  cmd_db = '0;
  logic        busy, irq, rd_ovf;
  logic [3:0]  rd_flags;
  logic [47:0] rd_mac;
  logic [14:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  viol_capture #(.LAT(LAT)) uut (
    .clk(clk), .rst(rst), .ev_kind(ev_kind), .ev_mac(ev_mac),
    .ev_src(ev_src), .ev_pvec(ev_pvec), .cmd_go(cmd_go),
    .cmd_code(cmd_code), .cmd_db(cmd_db), .busy(busy), .irq(irq),
    .rd_flags(rd_flags), .rd_ovf(rd_ovf), .rd_mac(rd_mac), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [3:0] k, input logic [47:0] m,
                      input logic [3:0] s, input logic [10:0] p);
    @(negedge clk);
    ev_kind = k; ev_mac = m; ev_src = s; ev_pvec = p;
    @(negedge clk);
    ev_kind = '0;
  endtask

  task automatic getclr(input logic [2:0] code, input logic [7:0] db, output int n);
    @(negedge clk);
    cmd_go = 1'b1; cmd_code = code; cmd_db = db;
    @(negedge clk);
    cmd_go = 1'b0;
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 rd_flags", 64'(rd_flags), 64'd0);
    chk("R1 rd_mac", 64'(rd_mac), 64'd0);
    chk("R1 rd_data", {63'd0, rd_ovf} | 64'(rd_data), 64'd0);

    // R2 R3 R6 R7: table walk
    for (int i = 0; i < 5; i++) begin
      fire(TBL[i].k, TBL[i].mac, TBL[i].src, TBL[i].pv);
      chk("R2 irq after event", 64'(irq), 64'd1);
      getclr(3'b111, 8'd0, n);
      chk("R5 busy length", 64'(n), 64'(LAT));
      chk("R3 R6 flags", 64'(rd_flags), 64'(TBL[i].k));
      chk("R6 mac", 64'(rd_mac), 64'(TBL[i].mac));
      chk("R6 data", 64'(rd_data), 64'({TBL[i].pv, TBL[i].src}));
      chk("R7 irq dropped", 64'(irq), 64'd0);
      chk("R4 no overflow", 64'(rd_ovf), 64'd0);
    end

    // R4 overflow: second event dropped
    fire(4'b0100, 48'h1111_2222_3333, 4'h3, 11'h008);
    fire(4'b1000, 48'h9999_8888_7777, 4'h9, 11'h200);
    chk("R4 irq held", 64'(irq), 64'd1);
    // R9 events between commands leave readback alone
    chk("R9 rd_mac unchanged", 64'(rd_mac), 64'(TBL[4].mac));
    getclr(3'b111, 8'd0, n);
    chk("R4 first kept flags", 64'(rd_flags), 64'd4);
    chk("R4 first kept mac", 64'(rd_mac), 64'h1111_2222_3333);
    chk("R4 overflow reported", 64'(rd_ovf), 64'd1);
    chk("R4 irq after", 64'(irq), 64'd0);

    // R8 empty get-and-clear; overflow cleared
    getclr(3'b111, 8'd0, n);
    chk("R8 flags", 64'(rd_flags), 64'd0);
    chk("R8 mac", 64'(rd_mac), 64'd0);
    chk("R8 data", 64'(rd_data), 64'd0);
    chk("R4 overflow cleared", 64'(rd_ovf), 64'd0);

    // R5 ignored commands
    fire(4'b0001, 48'h0000_0000_00AB, 4'h5, 11'h020);
    getclr(3'b110, 8'd0, n);
    chk("R5 wrong code no busy", 64'(n), 64'd0);
    chk("R5 wrong code irq", 64'(irq), 64'd1);
    getclr(3'b111, 8'd1, n);
    chk("R5 nonzero db no busy", 64'(n), 64'd0);
    chk("R9 rd unchanged after ignored", 64'(rd_flags), 64'd0);

    // R5 strobe held while busy does not extend or restart
    @(negedge clk);
    cmd_go = 1'b1; cmd_code = 3'b111; cmd_db = 8'd0;
    @(negedge clk);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    cmd_go = 1'b0;
    chk("R5 busy while strobe held", 64'(n), 64'(LAT));
    chk("R6 mac", 64'(rd_mac), 64'h0000_0000_00AB);
    @(negedge clk);
    chk("R5 no restart", 64'(busy), 64'd0);

    // R7 event in the completion cycle
    fire(4'b0010, 48'h0123_4567_89AB, 4'h1, 11'h002);
    @(negedge clk);
    cmd_go = 1'b1; cmd_code = 3'b111; cmd_db = 8'd0;
    @(negedge clk);
    cmd_go = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    ev_kind = 4'b1000; ev_mac = 48'hCAFE_0000_BEEF; ev_src = 4'hC; ev_pvec = 11'h100;
    @(negedge clk);
    ev_kind = '0;
    chk("R7 busy done", 64'(busy), 64'd0);
    chk("R7 irq kept", 64'(irq), 64'd1);
    chk("R7 old event read", 64'(rd_mac), 64'h0123_4567_89AB);
    getclr(3'b111, 8'd0, n);
    chk("R7 new event flags", 64'(rd_flags), 64'd8);
    chk("R7 new event data", 64'(rd_data), 64'({11'h100, 4'hC}));
    chk("R7 new event ovf", 64'(rd_ovf), 64'd0);
    chk("R7 irq low", 64'(irq), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule